// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is a one-byte-each-way mailbox between a legacy PC host bus and an embedded controller core. The host sees two ports: a data port (host address bit 2 low, the 60h port) and a command/status port (bit 2 high, the 64h port). A host write to either port lands in one input byte. The block flags that byte as full and keeps the address bit, so firmware can tell a command from a data byte. The core sends bytes back through one shared output byte. It writes them to either a keyboard-output or a mouse-output register, and that choice picks the host interrupt line (IRQ1 or IRQ12) that announces the byte.

Both host interrupt lines can run in level mode or in single-clock pulse mode, and either polarity can be chosen. The core gets two interrupts of its own: input-full and output-empty. Each has its own enable. Two sticky overrun bits record a byte that was overwritten before the other side took it.

The core register offsets are: 0 keyboard-output (write), 1 mouse-output (write), 2 input data (read), 3 status, 4 control, 5 overrun. Control bits: bit0 IRQ1 enable, bit1 IRQ12 enable, bit2 input-full core interrupt enable, bit3 output-empty core interrupt enable, bit4 pulse mode, bit5 invert host IRQ lines.

Top module: `kbc_mailbox`

## Requirements
- R1: After reset the status byte reads 00h, both host IRQ lines and both core interrupts are 0, and the overrun register reads 00h.
- R2: A host write to either port stores the byte as input data and sets input-full (status bit 1). Status bit 3 captures the host address bit: 0 after a 60h write, 1 after a 64h write.
- R3: A core read of offset 2 returns the input byte and clears input-full.
- R4: A core write to offset 0 or offset 1 loads the output byte and sets output-full (status bit 0).
- R5: A host read of the 64h port returns the status byte and changes nothing. A host read of the 60h port returns the output byte and clears output-full.
- R6: In level mode (control bit4 = 0), IRQ1 is active while output-full is set by a keyboard-output write with control bit0 set. IRQ12 is active likewise after a mouse-output write with control bit1 set. The line drops on the host read of 60h.
- R7: In pulse mode (control bit4 = 1), each enabled keyboard-output or mouse-output write gives exactly one active clock on the matching line, in the cycle after the write.
- R8: Control bit5 = 1 inverts both host IRQ lines, in either mode.
- R9: The core input-full interrupt equals control bit2 AND input-full. The core output-empty interrupt equals control bit3 AND NOT output-full.
- R10: An output write while output-full is set replaces the byte and sets overrun bit0. A host write while input-full is set replaces the byte and sets overrun bit1. Writing 1 to a bit of offset 5 clears that bit.
- R11: When a host 60h read and a core output write fall in one cycle, the host gets the old byte, output-full stays set with the new byte, and no overrun is flagged. When a host write and a core offset-2 read fall in one cycle, the core gets the old byte, input-full stays set with the new byte, and no overrun is flagged.
- R12: A core write to offset 3 changes only status bits 7:4 and 2. Bits 0, 1 and 3 stay under hardware control.
- R13: With the matching enable clear, an output write leaves that host IRQ line inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe, one clock per access |
| hostRd | input | 1 | Host read strobe, one clock per access |
| hostA2 | input | 1 | Host address bit 2: 0 data port, 1 command/status port |
| hostWrData | input | DATA_W | Host write byte |
| hostRdData | output | DATA_W | Host read byte (combinational) |
| coreWr | input | 1 | Core write strobe |
| coreRd | input | 1 | Core read strobe |
| coreAddr | input | CORE_AW | Core register offset |
| coreWrData | input | DATA_W | Core write byte |
| coreRdData | output | DATA_W | Core read byte (combinational) |
| irq1 | output | 1 | Host keyboard interrupt line |
| irq12 | output | 1 | Host mouse interrupt line |
| coreIbfIrq | output | 1 | Input-full interrupt to the core |
| coreObeIrq | output | 1 | Output-empty interrupt to the core |

## Verification
The host and core buses are independent, so a host consume and a core produce can fall in the same clock on either buffer. That can happen with a host 60h read and a core output write, or with a host write and a core input-data read. The bench drives both strobes in the same cycle. It checks the byte returned on the consuming side and checks that the full flag stays set. It then reads the overrun register, which must stay clear, and reads the second byte back to confirm that it landed.

// File: rtl/kbc_mailbox_pkg.sv
package kbc_mailbox_pkg;

  // Core register offsets
  localparam int REG_KBD_OUT   = 0;
  localparam int REG_MOUSE_OUT = 1;
  localparam int REG_IN_DATA   = 2;
  localparam int REG_STATUS    = 3;
  localparam int REG_CONTROL   = 4;
  localparam int REG_OVERRUN   = 5;

  // Status bit positions
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_A2  = 3;

  typedef struct packed {
    logic [1:0] spare;
    logic       invert;
    logic       pulseMode;
    logic       obeIe;
    logic       ibfIe;
    logic       mouseEn;
    logic       kbdEn;
  } ctlReg_t;

  typedef struct packed {
    logic hostInWr;
    logic hostOutRd;
    logic kbdWr;
    logic mouseWr;
    logic inRd;
    logic statWr;
    logic ctlWr;
    logic ovrWr;
  } mbxStrobes_t;

endpackage

// File: rtl/kbc_mailbox_ctrl.sv
module kbc_mailbox_ctrl
  import kbc_mailbox_pkg::*;
#(
  parameter int CORE_AW = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWr,
  input  logic               hostRd,
  input  logic               hostA2,
  input  logic               coreWr,
  input  logic               coreRd,
  input  logic [CORE_AW-1:0] coreAddr,
  input  ctlReg_t            ctl,
  input  logic               obf,
  input  logic               ibf,
  input  logic               obfFromMouse,
  output mbxStrobes_t        stb,
  output logic               irq1,
  output logic               irq12,
  output logic               coreIbfIrq,
  output logic               coreObeIrq
);

  localparam logic [CORE_AW-1:0] A_KBD   = CORE_AW'(REG_KBD_OUT);
  localparam logic [CORE_AW-1:0] A_MOUSE = CORE_AW'(REG_MOUSE_OUT);
  localparam logic [CORE_AW-1:0] A_IN    = CORE_AW'(REG_IN_DATA);
  localparam logic [CORE_AW-1:0] A_STAT  = CORE_AW'(REG_STATUS);
  localparam logic [CORE_AW-1:0] A_CTL   = CORE_AW'(REG_CONTROL);
  localparam logic [CORE_AW-1:0] A_OVR   = CORE_AW'(REG_OVERRUN);

  always_comb begin
    stb           = '0;
    stb.hostInWr  = hostWr;
    stb.hostOutRd = hostRd && !hostA2;
    stb.kbdWr     = coreWr && (coreAddr == A_KBD);
    stb.mouseWr   = coreWr && (coreAddr == A_MOUSE);
    stb.inRd      = coreRd && (coreAddr == A_IN);
    stb.statWr    = coreWr && (coreAddr == A_STAT);
    stb.ctlWr     = coreWr && (coreAddr == A_CTL);
    stb.ovrWr     = coreWr && (coreAddr == A_OVR);
  end

  logic kbdPulse, mousePulse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kbdPulse   <= 1'b0;
      mousePulse <= 1'b0;
    end else begin
      kbdPulse   <= stb.kbdWr && ctl.kbdEn && ctl.pulseMode;
      mousePulse <= stb.mouseWr && ctl.mouseEn && ctl.pulseMode;
    end
  end

  logic kbdLevel, mouseLevel, irq1Act, irq12Act;

  always_comb begin
    kbdLevel   = obf && !obfFromMouse && ctl.kbdEn;
    mouseLevel = obf && obfFromMouse && ctl.mouseEn;
    irq1Act    = ctl.pulseMode ? kbdPulse : kbdLevel;
    irq12Act   = ctl.pulseMode ? mousePulse : mouseLevel;
    irq1       = irq1Act ^ ctl.invert;
    irq12      = irq12Act ^ ctl.invert;
    coreIbfIrq = ctl.ibfIe && ibf;
    coreObeIrq = ctl.obeIe && !obf;
  end

  // R7
  pulse_irq1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.kbdWr && ctl.kbdEn && ctl.pulseMode) |=> (irq1 != ctl.invert));

  // R7
  pulse_irq12_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.mouseWr && ctl.mouseEn && ctl.pulseMode) |=> (irq12 != ctl.invert));

  // R6
  level_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.hostOutRd && !stb.kbdWr && !stb.mouseWr && !stb.ctlWr && !ctl.pulseMode)
      |=> (irq1 == ctl.invert) && (irq12 == ctl.invert));

endmodule

// File: rtl/kbc_mailbox_dp.sv
module kbc_mailbox_dp
  import kbc_mailbox_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CORE_AW = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  mbxStrobes_t        stb,
  input  logic               hostA2,
  input  logic [DATA_W-1:0]  hostWrData,
  input  logic [DATA_W-1:0]  coreWrData,
  input  logic [CORE_AW-1:0] coreAddr,
  output logic [DATA_W-1:0]  hostRdData,
  output logic [DATA_W-1:0]  coreRdData,
  output ctlReg_t            ctl,
  output logic               obf,
  output logic               ibf,
  output logic               obfFromMouse
);

  logic [DATA_W-1:0] inBuf, outBuf;
  logic              a2Flag;
  logic [3:0]        userHi;
  logic              userB2;
  logic              ovrOut, ovrIn;
  logic [7:0]        status;

  logic outWrite;
  assign outWrite = stb.kbdWr || stb.mouseWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inBuf  <= '0;
      ibf    <= 1'b0;
      a2Flag <= 1'b0;
      ovrIn  <= 1'b0;
    end else begin
      if (stb.hostInWr) begin
        inBuf  <= hostWrData;
        a2Flag <= hostA2;
        ibf    <= 1'b1;
      end else if (stb.inRd) begin
        ibf <= 1'b0;
      end
      if (stb.hostInWr && ibf && !stb.inRd) ovrIn <= 1'b1;
      else if (stb.ovrWr && coreWrData[1]) ovrIn <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outBuf       <= '0;
      obf          <= 1'b0;
      obfFromMouse <= 1'b0;
      ovrOut       <= 1'b0;
    end else begin
      if (outWrite) begin
        outBuf       <= coreWrData;
        obf          <= 1'b1;
        obfFromMouse <= stb.mouseWr;
      end else if (stb.hostOutRd) begin
        obf <= 1'b0;
      end
      if (outWrite && obf && !stb.hostOutRd) ovrOut <= 1'b1;
      else if (stb.ovrWr && coreWrData[0]) ovrOut <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctl    <= '0;
      userHi <= '0;
      userB2 <= 1'b0;
    end else begin
      if (stb.ctlWr) ctl <= ctlReg_t'(coreWrData[7:0]);
      if (stb.statWr) begin
        userHi <= coreWrData[7:4];
        userB2 <= coreWrData[2];
      end
    end
  end

  always_comb begin
    status         = '0;
    status[7:4]    = userHi;
    status[2]      = userB2;
    status[ST_OBF] = obf;
    status[ST_IBF] = ibf;
    status[ST_A2]  = a2Flag;
  end

  always_comb begin
    hostRdData = hostA2 ? DATA_W'(status) : outBuf;
    unique case (int'(coreAddr))
      REG_IN_DATA: coreRdData = inBuf;
      REG_STATUS:  coreRdData = DATA_W'(status);
      REG_CONTROL: coreRdData = DATA_W'(ctl);
      REG_OVERRUN: coreRdData = DATA_W'({ovrIn, ovrOut});
      default:     coreRdData = '0;
    endcase
  end

  // R2
  host_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.hostInWr |=> ibf && (a2Flag == $past(hostA2)) && (inBuf == $past(hostWrData)));

  // R3
  in_read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.inRd && !stb.hostInWr) |=> !ibf);

  // R4
  out_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    outWrite |=> obf && (outBuf == $past(coreWrData)));

  // R5
  host_consume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.hostOutRd && !outWrite) |=> !obf);

  // R10
  out_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outWrite && obf && !stb.hostOutRd) |=> ovrOut);

  // R11
  out_collide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outWrite && stb.hostOutRd && !ovrOut) |=> !ovrOut && obf);

endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox
  import kbc_mailbox_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CORE_AW = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWr,
  input  logic               hostRd,
  input  logic               hostA2,
  input  logic [DATA_W-1:0]  hostWrData,
  output logic [DATA_W-1:0]  hostRdData,
  input  logic               coreWr,
  input  logic               coreRd,
  input  logic [CORE_AW-1:0] coreAddr,
  input  logic [DATA_W-1:0]  coreWrData,
  output logic [DATA_W-1:0]  coreRdData,
  output logic               irq1,
  output logic               irq12,
  output logic               coreIbfIrq,
  output logic               coreObeIrq
);

  mbxStrobes_t stb;
  ctlReg_t     ctl;
  logic        obf, ibf, obfFromMouse;

  kbc_mailbox_ctrl #(.CORE_AW(CORE_AW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostWr(hostWr), .hostRd(hostRd), .hostA2(hostA2),
    .coreWr(coreWr), .coreRd(coreRd), .coreAddr(coreAddr),
    .ctl(ctl), .obf(obf), .ibf(ibf), .obfFromMouse(obfFromMouse),
    .stb(stb), .irq1(irq1), .irq12(irq12),
    .coreIbfIrq(coreIbfIrq), .coreObeIrq(coreObeIrq)
  );

  kbc_mailbox_dp #(.DATA_W(DATA_W), .CORE_AW(CORE_AW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .hostA2(hostA2), .hostWrData(hostWrData),
    .coreWrData(coreWrData), .coreAddr(coreAddr),
    .hostRdData(hostRdData), .coreRdData(coreRdData),
    .ctl(ctl), .obf(obf), .ibf(ibf), .obfFromMouse(obfFromMouse)
  );

endmodule

// File: tb/kbc_mailbox_tb.sv
module kbc_mailbox_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWr = 1'b0, hostRd = 1'b0, hostA2 = 1'b0;
  logic [7:0] hostWrData = '0, hostRdData;
  logic       coreWr = 1'b0, coreRd = 1'b0;
  logic [2:0] coreAddr = '0;
  logic [7:0] coreWrData = '0, coreRdData;
  logic       irq1, irq12, coreIbfIrq, coreObeIrq;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #10 clk = ~clk;

  kbc_mailbox u_dut (
    .clk(clk), .rstN(rstN),
    .hostWr(hostWr), .hostRd(hostRd), .hostA2(hostA2),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .coreWr(coreWr), .coreRd(coreRd), .coreAddr(coreAddr),
    .coreWrData(coreWrData), .coreRdData(coreRdData),
    .irq1(irq1), .irq12(irq12),
    .coreIbfIrq(coreIbfIrq), .coreObeIrq(coreObeIrq)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(logic a2, logic [7:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostA2 = a2; hostWrData = d;
    @(negedge clk);
    hostWr = 1'b0; hostA2 = 1'b0;
  endtask

  task automatic hostRead(logic a2, output logic [7:0] d);
    @(negedge clk);
    hostRd = 1'b1; hostA2 = a2;
    #1 d = hostRdData;
    @(negedge clk);
    hostRd = 1'b0; hostA2 = 1'b0;
  endtask

  task automatic coreWrite(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    coreWr = 1'b1; coreAddr = a; coreWrData = d;
    @(negedge clk);
    coreWr = 1'b0; coreAddr = '0;
  endtask

  task automatic coreRead(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    coreRd = 1'b1; coreAddr = a;
    #1 d = coreRdData;
    @(negedge clk);
    coreRd = 1'b0; coreAddr = '0;
  endtask

  task automatic testReset();
    logic [7:0] d;
    hostRead(1'b1, d);
    check("R1 status", d, 8'h00);
    check("R1 irq1", irq1, 0);
    check("R1 irq12", irq12, 0);
    check("R1 coreIrqs", {coreIbfIrq, coreObeIrq}, 0);
    coreRead(3'd5, d);
    check("R1 overrun", d, 8'h00);
  endtask

  task automatic testHostToCore();
    logic [7:0] d;
    hostWrite(1'b0, 8'h5A);
    coreRead(3'd3, d);
    check("R2 status after 60h write", d, 8'h02);
    coreRead(3'd2, d);
    check("R3 input byte", d, 8'h5A);
    coreRead(3'd3, d);
    check("R3 IBF cleared", d, 8'h00);
    hostWrite(1'b1, 8'hAA);
    coreRead(3'd3, d);
    check("R2 status after 64h write", d, 8'h0A);
    coreRead(3'd2, d);
    check("R3 command byte", d, 8'hAA);
    coreRead(3'd3, d);
    check("R2 A2 kept after read", d, 8'h08);
  endtask

  task automatic testLevel();
    logic [7:0] d;
    coreWrite(3'd4, 8'h03);
    coreWrite(3'd0, 8'h11);
    check("R6 irq1 level on", irq1, 1);
    check("R6 irq12 idle", irq12, 0);
    hostRead(1'b1, d);
    check("R4/R5 status OBF", d, 8'h09);
    hostRead(1'b0, d);
    check("R5 output byte", d, 8'h11);
    check("R6 irq1 dropped", irq1, 0);
    hostRead(1'b1, d);
    check("R5 OBF cleared", d[0], 0);
    coreWrite(3'd1, 8'h22);
    check("R6 irq12 level on", irq12, 1);
    check("R6 irq1 stays off", irq1, 0);
    hostRead(1'b0, d);
    check("R4 mouse byte", d, 8'h22);
    check("R6 irq12 dropped", irq12, 0);
  endtask

  task automatic testDisabled();
    logic [7:0] d;
    coreWrite(3'd4, 8'h00);
    coreWrite(3'd0, 8'h33);
    check("R13 irq1 disabled", irq1, 0);
    coreWrite(3'd4, 8'h01);
    coreWrite(3'd4, 8'h00);
    hostRead(1'b0, d);
    coreWrite(3'd1, 8'h34);
    check("R13 irq12 disabled", irq12, 0);
    hostRead(1'b0, d);
    check("R13 byte still delivered", d, 8'h34);
  endtask

  task automatic testPulse();
    logic [7:0] d;
    coreWrite(3'd4, 8'h13);
    coreWrite(3'd0, 8'h44);
    check("R7 irq1 pulse high", irq1, 1);
    @(negedge clk);
    check("R7 irq1 pulse one clock", irq1, 0);
    hostRead(1'b0, d);
    coreWrite(3'd1, 8'h45);
    check("R7 irq12 pulse high", irq12, 1);
    check("R7 irq1 quiet", irq1, 0);
    @(negedge clk);
    check("R7 irq12 pulse one clock", irq12, 0);
    hostRead(1'b0, d);
  endtask

  task automatic testInvert();
    logic [7:0] d;
    coreWrite(3'd4, 8'h23);
    check("R8 idle irq1 inverted", irq1, 1);
    check("R8 idle irq12 inverted", irq12, 1);
    coreWrite(3'd0, 8'h46);
    check("R8 irq1 active low", irq1, 0);
    hostRead(1'b0, d);
    check("R8 irq1 released high", irq1, 1);
    coreWrite(3'd4, 8'h33);
    coreWrite(3'd1, 8'h47);
    check("R8 irq12 pulse active low", irq12, 0);
    @(negedge clk);
    check("R8 irq12 pulse ends high", irq12, 1);
    hostRead(1'b0, d);
  endtask

  task automatic testCoreIrq();
    logic [7:0] d;
    coreWrite(3'd4, 8'h0C);
    check("R9 OBE irq when empty", coreObeIrq, 1);
    check("R9 IBF irq when empty", coreIbfIrq, 0);
    hostWrite(1'b0, 8'h50);
    check("R9 IBF irq raised", coreIbfIrq, 1);
    coreWrite(3'd0, 8'h51);
    check("R9 OBE irq cleared", coreObeIrq, 0);
    coreRead(3'd2, d);
    check("R9 IBF irq cleared", coreIbfIrq, 0);
    hostRead(1'b0, d);
    check("R9 OBE irq back", coreObeIrq, 1);
    coreWrite(3'd4, 8'h00);
    check("R9 OBE irq disabled", coreObeIrq, 0);
  endtask

  task automatic testOverrun();
    logic [7:0] d;
    coreWrite(3'd0, 8'h60);
    coreWrite(3'd1, 8'h61);
    coreRead(3'd5, d);
    check("R10 output overrun", d, 8'h01);
    hostRead(1'b0, d);
    check("R10 output overwritten", d, 8'h61);
    hostWrite(1'b0, 8'h62);
    hostWrite(1'b1, 8'h63);
    coreRead(3'd5, d);
    check("R10 both overruns", d, 8'h03);
    coreRead(3'd2, d);
    check("R10 input overwritten", d, 8'h63);
    coreWrite(3'd5, 8'h01);
    coreRead(3'd5, d);
    check("R10 clear output bit only", d, 8'h02);
    coreWrite(3'd5, 8'h02);
    coreRead(3'd5, d);
    check("R10 cleared", d, 8'h00);
  endtask

  task automatic testCollide();
    logic [7:0] d;
    coreWrite(3'd0, 8'h66);
    @(negedge clk);
    hostRd = 1'b1; hostA2 = 1'b0;
    coreWr = 1'b1; coreAddr = 3'd0; coreWrData = 8'h77;
    #1 d = hostRdData;
    @(negedge clk);
    hostRd = 1'b0; coreWr = 1'b0;
    check("R11 host gets old byte", d, 8'h66);
    coreRead(3'd3, d);
    check("R11 OBF stays set", d[0], 1);
    coreRead(3'd5, d);
    check("R11 no output overrun", d, 8'h00);
    hostRead(1'b0, d);
    check("R11 new byte delivered", d, 8'h77);
    hostWrite(1'b0, 8'h81);
    @(negedge clk);
    coreRd = 1'b1; coreAddr = 3'd2;
    hostWr = 1'b1; hostA2 = 1'b0; hostWrData = 8'h82;
    #1 d = coreRdData;
    @(negedge clk);
    coreRd = 1'b0; hostWr = 1'b0;
    check("R11 core gets old byte", d, 8'h81);
    coreRead(3'd3, d);
    check("R11 IBF stays set", d[1], 1);
    coreRead(3'd5, d);
    check("R11 no input overrun", d, 8'h00);
    coreRead(3'd2, d);
    check("R11 new input byte", d, 8'h82);
  endtask

  task automatic testStatusWrite();
    logic [7:0] d;
    coreWrite(3'd3, 8'hFF);
    hostRead(1'b1, d);
    check("R12 only user bits written", d, 8'hF4);
    hostWrite(1'b1, 8'h90);
    hostRead(1'b1, d);
    check("R12 hardware bits kept", d, 8'hFE);
    coreWrite(3'd3, 8'h00);
    coreRead(3'd3, d);
    check("R12 IBF and A2 survive write", d, 8'h0A);
    coreRead(3'd2, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testHostToCore();
    testLevel();
    testDisabled();
    testPulse();
    testInvert();
    testCoreIrq();
    testOverrun();
    testCollide();
    testStatusWrite();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule